// File: doc/BRIEF.md
# Gray-scale PWM output sequencer

The block turns sixteen 8-bit intensity values into sixteen on/off drive enables whose on-time is a whole number of gray-scale clock periods. The gray-scale clock and the blank input come from outside the system clock domain. Each one passes through a two-flop synchronizer, and the gray-scale clock is then edge-detected. A burst starts only after blank is released. The sequencer first waits for a rising edge of the gray-scale clock and then for the next falling edge. On that falling edge every channel with a nonzero value turns on and an 8-bit count starts from zero.

The counter advances once per prescaled tick. A tick is every (code+1)-th falling edge of the gray-scale clock when brightness control is enabled, and every falling edge when it is disabled. A channel stays on while the count is below its value, so its on-time is value × divisor gray-scale periods. The count stops at its maximum and stays there until blank is pulsed again. An 8-channel mode lets each of the first eight bytes drive a pair of adjacent outputs. An external shutdown request masks every output while the count keeps running. The "any channel on" flag lets a neighbouring latch block hold off brightness updates while the outputs are lit.

Top module: `gs_pwm_seq`

## Requirements
- R1: While blank_i stays high, ch_en_o is all zero from the fourth system clock edge onward; a blank raised in the middle of a burst ends it.
- R2: After blank_i falls, the burst starts at the first falling gray-scale edge that follows a rising gray-scale edge; a falling edge seen before that rising edge does not start it. Turn-on lags the start edge by a fixed latency of 1 to 5 system clocks.
- R3: A channel with value v (bits [8i+7:8i] of gs_data_i for channel i) stays on for exactly v × divisor gray-scale periods.
- R4: A channel whose value is zero never turns on.
- R5: With bc_en_i high, the divisor equals div_code_i + 1: code 0 gives 1 and code 7 gives 8.
- R6: With bc_en_i low, the divisor is 1 whatever div_code_i holds.
- R7: With mode16_i low, byte k drives outputs 2k and 2k+1 together, and bytes 8 to 15 have no effect.
- R8: While shdn_i is high every output is off, and the count keeps running, so the turn-off time after shdn_i is released is unchanged.
- R9: After 255 counted ticks the count holds, and no channel turns on again until blank_i is pulsed; a new release starts a fresh burst.
- R10: any_on_o is high exactly when at least one bit of ch_en_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gsclk_i | input | 1 | Gray-scale clock, asynchronous |
| blank_i | input | 1 | Forces all outputs off while high, asynchronous |
| mode16_i | input | 1 | 1: 16 independent channels, 0: 8 channel pairs |
| bc_en_i | input | 1 | Brightness control enable; low bypasses the divider |
| div_code_i | input | 3 | Divider code; divisor is code+1 |
| gs_data_i | input | 128 | Channel values, byte i at bits [8i+7:8i] |
| shdn_i | input | 1 | Shutdown request, masks all outputs |
| ch_en_o | output | 16 | Channel drive enables |
| any_on_o | output | 1 | High while any enable is high |

## Verification
Bursts are run with mixed values in 16-channel mode: zeros, 1, mid values and 255. The widths measured at each falling enable must match the values one for one, which separates a correct compare from an off-by-one count or a wrongly ordered byte. The same data pattern is then run under every divider code with brightness control on, and under code 7 with it off, which separates a correct divisor from a missing bypass. The 8-channel run puts values in the upper bytes that would show up in some output if those bytes were used. Blank is released while the gray-scale clock is high, so that a start on the early falling edge stands apart from a start on the correct edge. Separate runs raise blank and shutdown in the middle of a burst; the shutdown run shows that the turn-off time is unchanged.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_WFALL = 2'd2,
    ST_RUN   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/gs_sync2.sv
module gs_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gs_prescale.sv
module gs_prescale #(
  parameter int DW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          fall_i,
  input  logic          bc_en_i,
  input  logic [DW-1:0] code_i,
  output logic          tick_o
);
  logic [DW-1:0] pre_q;
  logic [DW-1:0] lim;

  // bypass forces divide-by-one
  assign lim    = bc_en_i ? code_i : '0;
  assign tick_o = fall_i && (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (clear_i) begin
      pre_q <= '0;
    end else if (fall_i) begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/gs_seq_ctrl.sv
module gs_seq_ctrl
  import gs_pwm_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gs_lvl_i,
  input  logic          blank_lvl_i,
  input  logic          tick_i,
  output logic          fall_o,
  output logic          run_o,
  output logic [GW-1:0] cnt_o
);
  localparam logic [GW-1:0] CMAX = {GW{1'b1}};

  logic    gs_d;
  logic    rise;
  seq_st_e st_q, st_d;
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gs_d <= 1'b0;
    else         gs_d <= gs_lvl_i;
  end

  assign rise   = gs_lvl_i && !gs_d;
  assign fall_o = !gs_lvl_i && gs_d;

  always_comb begin
    st_d = st_q;
    if (blank_lvl_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_ARM;
        ST_ARM:   if (rise)   st_d = ST_WFALL;
        ST_WFALL: if (fall_o) st_d = ST_RUN;
        ST_RUN:   st_d = ST_RUN;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // count restarts from zero on every entry to run, saturates at max
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (st_q != ST_RUN) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != CMAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o = (st_q == ST_RUN);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/gs_chan_cmp.sv
module gs_chan_cmp #(
  parameter int NCH = 16,
  parameter int GW  = 8
) (
  input  logic [NCH*GW-1:0] data_i,
  input  logic              mode16_i,
  input  logic              run_i,
  input  logic              shdn_i,
  input  logic [GW-1:0]     cnt_i,
  output logic [NCH-1:0]    en_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int PAIR = i / 2;
    logic [GW-1:0] val;
    assign val     = mode16_i ? data_i[i*GW +: GW] : data_i[PAIR*GW +: GW];
    assign en_o[i] = run_i && !shdn_i && (cnt_i < val);
  end
endmodule

// File: rtl/gs_pwm_seq.sv
module gs_pwm_seq
  import gs_pwm_pkg::*;
#(
  parameter int NCH = 16,
  parameter int GW  = 8,
  parameter int DW  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gsclk_i,
  input  logic              blank_i,
  input  logic              mode16_i,
  input  logic              bc_en_i,
  input  logic [DW-1:0]     div_code_i,
  input  logic [NCH*GW-1:0] gs_data_i,
  input  logic              shdn_i,
  output logic [NCH-1:0]    ch_en_o,
  output logic              any_on_o
);
  logic          gs_lvl, blank_lvl;
  logic          fall_w, tick_w, run_w;
  logic [GW-1:0] cnt_w;

  gs_sync2 #(.RST_VAL(1'b0)) u_sync_gs (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(gsclk_i), .q_o(gs_lvl)
  );

  gs_sync2 #(.RST_VAL(1'b1)) u_sync_blank (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(blank_i), .q_o(blank_lvl)
  );

  gs_seq_ctrl #(.GW(GW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gs_lvl_i   (gs_lvl),
    .blank_lvl_i(blank_lvl),
    .tick_i     (tick_w),
    .fall_o     (fall_w),
    .run_o      (run_w),
    .cnt_o      (cnt_w)
  );

  gs_prescale #(.DW(DW)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!run_w),
    .fall_i (fall_w),
    .bc_en_i(bc_en_i),
    .code_i (div_code_i),
    .tick_o (tick_w)
  );

  gs_chan_cmp #(.NCH(NCH), .GW(GW)) u_cmp (
    .data_i  (gs_data_i),
    .mode16_i(mode16_i),
    .run_i   (run_w),
    .shdn_i  (shdn_i),
    .cnt_i   (cnt_w),
    .en_o    (ch_en_o)
  );

  assign any_on_o = |ch_en_o;
endmodule

// File: rtl/gs_pwm_seq_chk.sv
module gs_pwm_seq_chk #(
  parameter int NCH = 16,
  parameter int GW  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              blank_i,
  input logic              shdn_i,
  input logic              mode16_i,
  input logic [NCH*GW-1:0] gs_data_i,
  input logic [NCH-1:0]    ch_en_o,
  input logic              any_on_o,
  input logic              run_i,
  input logic [GW-1:0]     cnt_i
);
  localparam logic [GW-1:0] CMAX = {GW{1'b1}};

  p_blank_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && $past(blank_i) && $past(blank_i, 2) && $past(blank_i, 3)) |-> (ch_en_o == '0));

  p_shdn_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |-> !any_on_o);

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1));

  p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == CMAX) |=> (!run_i || cnt_i == CMAX));

  p_start_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_i == '0));

  for (genvar k = 0; k < NCH / 2; k++) begin : g_pair
    p_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode16_i |-> (ch_en_o[2*k] == ch_en_o[2*k+1]));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_zero
    p_zero_dark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode16_i && gs_data_i[i*GW +: GW] == '0) |-> !ch_en_o[i]);
  end
endmodule

bind gs_pwm_seq gs_pwm_seq_chk #(.NCH(NCH), .GW(GW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .blank_i  (blank_i),
  .shdn_i   (shdn_i),
  .mode16_i (mode16_i),
  .gs_data_i(gs_data_i),
  .ch_en_o  (ch_en_o),
  .any_on_o (any_on_o),
  .run_i    (run_w),
  .cnt_i    (cnt_w)
);

// File: tb/gs_pwm_seq_tb.sv
module gs_pwm_seq_tb;
  localparam int CLK_P = 10;
  localparam int NCH   = 16;
  localparam int GW    = 8;
  localparam int GSP   = 4;   // gray-scale period in system clocks

  typedef struct {
    int    ch;
    int    width;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              gsclk = 1'b0;
  logic              blank = 1'b1;
  logic              mode16 = 1'b1;
  logic              bc_en = 1'b0;
  logic [2:0]        code = 3'd0;
  logic [NCH*GW-1:0] gdata = '0;
  logic              shdn = 1'b0;
  logic [NCH-1:0]    ch_en;
  logic              any_on;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int gph = 0;
  int nfall = 0;
  int last_fall_cyc = 0;
  int start_idx = 0;
  bit mon_en = 0;
  bit started = 0;
  bit sat_watch = 0;
  bit finished = 0;
  logic [NCH-1:0] exp_zero = '0;
  logic [NCH-1:0] prev = '0;
  int rise_cyc [NCH];
  exp_t sb_q [$];

  gs_pwm_seq u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .gsclk_i   (gsclk),
    .blank_i   (blank),
    .mode16_i  (mode16),
    .bc_en_i   (bc_en),
    .div_code_i(code),
    .gs_data_i (gdata),
    .shdn_i    (shdn),
    .ch_en_o   (ch_en),
    .any_on_o  (any_on)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // gray-scale clock: 2 high, 2 low, changes at negedge
  initial begin
    forever begin
      @(negedge clk);
      gph = (gph + 1) % GSP;
      if (gsclk && !(gph < 2)) begin
        nfall++;
        last_fall_cyc = cyc;
      end
      gsclk = (gph < 2);
    end
  end

  // monitor: pops expected widths at each falling enable
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      for (int c = 0; c < NCH; c++) begin
        if (ch_en[c] && !prev[c]) begin
          rise_cyc[c] = cyc;
          if (mon_en) begin
            if (exp_zero[c]) chk(1'b0, "R4 zero channel lit", c, -1);
            if (sat_watch)   chk(1'b0, "R9 relit after saturation", c, -1);
            if (!started) begin
              started = 1;
              chk(nfall == start_idx, "R2 start edge index", nfall, start_idx);
              chk((cyc - last_fall_cyc) >= 1 && (cyc - last_fall_cyc) <= 5,
                  "R2 start latency", cyc - last_fall_cyc, 3);
              chk(any_on == 1'b1, "R10 flag on", any_on, 1);
            end
          end
        end
        if (!ch_en[c] && prev[c] && mon_en) begin
          if (sb_q.size() == 0) begin
            chk(1'b0, "R3 unexpected turn-off", c, -1);
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.ch == c, {e.tag, " channel order"}, c, e.ch);
            chk(e.width == cyc - rise_cyc[c], {e.tag, " width"}, cyc - rise_cyc[c], e.width);
          end
        end
      end
      prev = ch_en;
    end
  end

  function automatic logic [GW-1:0] byte_of(input int idx);
    return gdata[idx*GW +: GW];
  endfunction

  task automatic push_expect(input string tag);
    int d;
    d = bc_en ? int'(code) + 1 : 1;
    exp_zero = '0;
    for (int c = 0; c < NCH; c++) begin
      int b;
      b = mode16 ? c : c / 2;
      if (byte_of(b) == 0) exp_zero[c] = 1'b1;
    end
    for (int v = 1; v < 256; v++) begin
      for (int c = 0; c < NCH; c++) begin
        int b;
        b = mode16 ? c : c / 2;
        if (int'(byte_of(b)) == v) begin
          exp_t e;
          e.ch = c;
          e.width = v * d * GSP;
          e.tag = tag;
          sb_q.push_back(e);
        end
      end
    end
  endtask

  // release blank while the gray-scale clock is high, just after its rise
  task automatic release_blank();
    do step(); while (gph != 0);
    blank = 1'b0;
    start_idx = nfall + 2;
  endtask

  task automatic run_burst(input string tag);
    started = 0;
    sat_watch = 0;
    push_expect(tag);
    mon_en = 1;
    release_blank();
    while (sb_q.size() > 0) step();
    sat_watch = 1;
    repeat (60) step();
    chk(any_on == 1'b0 && ch_en == '0, {tag, " R9 quiet after burst"}, int'(ch_en), 0);
    chk(sb_q.size() == 0, {tag, " R3 queue drained"}, sb_q.size(), 0);
    sat_watch = 0;
    mon_en = 0;
    blank = 1'b1;
    repeat (6) step();
  endtask

  task automatic set_byte(input int idx, input int v);
    gdata[idx*GW +: GW] = v[GW-1:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    chk(ch_en == '0, "R1 reset outputs", int'(ch_en), 0);
    chk(any_on == 1'b0, "R10 reset flag", any_on, 0);

    // R3 R4 R6: mixed data, bypassed divider with a nonzero code
    mode16 = 1; bc_en = 0; code = 3'd7;
    set_byte(0, 1);   set_byte(1, 0);   set_byte(2, 2);    set_byte(3, 7);
    set_byte(4, 0);   set_byte(5, 16);  set_byte(6, 33);   set_byte(7, 64);
    set_byte(8, 100); set_byte(9, 128); set_byte(10, 3);   set_byte(11, 200);
    set_byte(12, 0);  set_byte(13, 5);  set_byte(14, 9);   set_byte(15, 255);
    run_burst("R6 bypass");

    // R5: every divider code
    bc_en = 1;
    for (int c = 0; c < NCH; c++) set_byte(c, (c * 3) % 11);
    for (int dc = 0; dc < 8; dc++) begin
      code = dc[2:0];
      run_burst("R5 divider");
    end

    // R9: saturation with divisor 2
    gdata = '0;
    set_byte(5, 255);
    code = 3'd1;
    run_burst("R9 saturate");

    // R7: pairs from low bytes, high bytes ignored
    mode16 = 0; bc_en = 0;
    set_byte(0, 4); set_byte(1, 0); set_byte(2, 9);  set_byte(3, 1);
    set_byte(4, 12); set_byte(5, 6); set_byte(6, 2); set_byte(7, 15);
    for (int c = 8; c < NCH; c++) set_byte(c, 8'hF0);
    run_burst("R7 pairs");

    // R1: blank raised mid-burst
    mode16 = 1;
    gdata = '0;
    set_byte(2, 200);
    release_blank();
    k = 0;
    while (!ch_en[2] && k < 100) begin step(); k++; end
    chk(ch_en[2] == 1'b1, "R1 burst lit before blank", ch_en[2], 1);
    repeat (50) step();
    blank = 1'b1;
    repeat (4) step();
    chk(ch_en == '0, "R1 blank mid-burst", int'(ch_en), 0);
    repeat (20) step();
    chk(ch_en == '0 && any_on == 1'b0, "R1 blank holds", int'(ch_en), 0);

    // R8: shutdown masks, count keeps running
    gdata = '0;
    set_byte(0, 200);
    release_blank();
    k = 0;
    while (!ch_en[0] && k < 100) begin step(); k++; end
    k = 0;
    repeat (100) begin step(); k++; end
    shdn = 1'b1;
    #1;
    chk(ch_en == '0, "R8 shutdown masks outputs", int'(ch_en), 0);
    chk(any_on == 1'b0, "R10 flag low in shutdown", any_on, 0);
    repeat (100) begin step(); k++; end
    chk(ch_en == '0, "R8 shutdown held", int'(ch_en), 0);
    shdn = 1'b0;
    #1;
    chk(ch_en[0] == 1'b1, "R8 resumes after shutdown", ch_en[0], 1);
    while (ch_en[0] && k < 2000) begin step(); k++; end
    chk(k == 200 * GSP, "R8 turn-off time unchanged", k, 200 * GSP);
    blank = 1'b1;
    repeat (6) step();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule